// File: doc/BRIEF.md
# Carry-Save Running-Sum Accumulator

This block sums a stream of unsigned operands, one per clock cycle if needed, without ever letting a carry travel more than one bit position while the stream is coming in. The running total is kept in redundant form: two vectors, one of sum bits and one of carry bits. Each bit position, or digit, therefore holds a value of 0, 1 or 2. Each new operand goes through one row of full adders. At digit i, the full adder combines the two stored bits with operand bit i. Its sum bit stays at digit i, and its carry-out becomes the carry bit of digit i+1.

When the caller asks for the result, the block takes the two vectors as they stand. One cycle later it adds them with a single carry-propagate adder. The binary result then appears together with a one-cycle valid pulse.

A sequence begins with a load strobe, which places the first operand in the sum vector and clears the carry vector. Further operands arrive with an add strobe. A finish strobe requests the result. The output is wide enough for the full sum of the largest allowed number of operands.

Top module: `csa_accum`

## Requirements
- R1: After reset, `res_valid_o` is 0, `res_o` is 0 and the stored total is zero, so a finish request issued before any operand reports 0.
- R2: A load strobe replaces whatever total was held with the operand on `op_i`. Any earlier total is discarded.
- R3: An add strobe increases the stored total by `op_i`, modulo 2^GW. After every add, carry bit 0 is zero, and each digit takes its new carry bit only from the digit directly below it.
- R4: An operand is accepted on every cycle in which `add_i` is high, including back-to-back cycles.
- R5: If `fin_i` is high at rising edge k, then at edge k+1 `res_o` takes the total as it stood just before edge k and `res_valid_o` goes high. `res_valid_o` falls at edge k+2 unless another finish was requested.
- R6: `res_o` keeps its last value until the next finish request completes.
- R7: A finish request that arrives in the same cycle as a load or an add reports the total from before that cycle's update. The load or add still takes effect.
- R8: Summing MAX_OPS operands of all ones gives exactly MAX_OPS*(2^W-1), with no bit lost.
- R9: When `load_i` and `add_i` are both high, the load wins and the add operand is ignored.
- R10: `res_o` is GW = W + clog2(MAX_OPS) bits wide. A sequence with more than MAX_OPS operands wraps modulo 2^GW.
- R11: A finish request does not change the stored total. A second finish gives the same result, and later adds continue from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new total with `op_i` |
| add_i | input | 1 | Add `op_i` to the total |
| fin_i | input | 1 | Request the binary result |
| op_i | input | W | Unsigned operand |
| res_o | output | GW | Binary total |
| res_valid_o | output | 1 | One-cycle pulse when `res_o` is new |

## Verification
The bench runs a table of operand sequences, from 1 to 16 long. The sequences are drawn from a pseudo-random generator or made entirely of all-ones values, and the operands are added on back-to-back cycles. A row that dropped or misrouted a carry would give a wrong sum. This shows up most sharply with all-ones operands, where every digit saturates at weight 2. Directed cases then cover the following:
- a finish arriving together with a load or an add, where a snapshot taken one edge late would report the new total;
- load-over-add priority;
- repeated finish requests, which catch a design that clears the total on finish;
- a 17-operand run, which must wrap at the output width instead of saturating.

// File: rtl/csa_accum_pkg.sv
package csa_accum_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_ADD  = 2'd2
  } upd_e;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int GW = 12
) (
  input  logic [GW-1:0] s_i,
  input  logic [GW-1:0] c_i,
  input  logic [GW-1:0] a_i,
  output logic [GW-1:0] s_o,
  output logic [GW-1:0] c_o,
  output logic          top_co_o
);
  import csa_accum_pkg::*;

  logic [GW-1:0] co_w;

  for (genvar i = 0; i < GW; i++) begin : g_digit
    assign s_o[i]  = fa_sum(s_i[i], c_i[i], a_i[i]);
    assign co_w[i] = fa_carry(s_i[i], c_i[i], a_i[i]);
  end

  assign c_o      = {co_w[GW-2:0], 1'b0};
  assign top_co_o = co_w[GW-1];
endmodule

// File: rtl/csa_regs.sv
module csa_regs #(
  parameter int W  = 8,
  parameter int GW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  csa_accum_pkg::upd_e    upd_i,
  input  logic [W-1:0]           op_i,
  input  logic [GW-1:0]          row_s_i,
  input  logic [GW-1:0]          row_c_i,
  output logic [GW-1:0]          sum_q,
  output logic [GW-1:0]          carry_q
);
  import csa_accum_pkg::*;

  localparam int XW = GW - W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else begin
      case (upd_i)
        UPD_LOAD: begin
          sum_q   <= {{XW{1'b0}}, op_i};
          carry_q <= '0;
        end
        UPD_ADD: begin
          sum_q   <= row_s_i;
          carry_q <= row_c_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpa_stage.sv
module cpa_stage #(
  parameter int GW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_i,
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  output logic [GW-1:0] res_o,
  output logic          valid_o
);
  import csa_accum_pkg::*;

  function automatic logic [GW-1:0] cpa_add(input logic [GW-1:0] a, input logic [GW-1:0] b);
    logic [GW-1:0] r;
    logic c;
    c = 1'b0;
    for (int i = 0; i < GW; i++) begin
      r[i] = fa_sum(a[i], b[i], c);
      c    = fa_carry(a[i], b[i], c);
    end
    return r;
  endfunction

  logic [GW-1:0] a_q, b_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      pend_q  <= 1'b0;
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      pend_q  <= fin_i;
      valid_o <= pend_q;
      if (fin_i) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      if (pend_q) res_o <= cpa_add(a_q, b_q);
    end
  end
endmodule

// File: rtl/csa_accum.sv
module csa_accum #(
  parameter int W       = 8,
  parameter int MAX_OPS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_i,
  input  logic                              add_i,
  input  logic                              fin_i,
  input  logic [W-1:0]                      op_i,
  output logic [W+$clog2(MAX_OPS)-1:0]      res_o,
  output logic                              res_valid_o
);
  import csa_accum_pkg::*;

  localparam int GW = W + $clog2(MAX_OPS);
  localparam int XW = GW - W;
  localparam int CW = $clog2(MAX_OPS + 2);

  upd_e          upd_w;
  logic [GW-1:0] sum_q, carry_q;
  logic [GW-1:0] row_s_w, row_c_w, op_ext_w;
  logic          top_co_w;

  always_comb begin
    if (load_i)     upd_w = UPD_LOAD;
    else if (add_i) upd_w = UPD_ADD;
    else            upd_w = UPD_HOLD;
  end

  assign op_ext_w = {{XW{1'b0}}, op_i};

  csa_row #(.GW(GW)) u_row (
    .s_i(sum_q), .c_i(carry_q), .a_i(op_ext_w),
    .s_o(row_s_w), .c_o(row_c_w), .top_co_o(top_co_w)
  );

  csa_regs #(.W(W), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_w), .op_i(op_i),
    .row_s_i(row_s_w), .row_c_i(row_c_w),
    .sum_q(sum_q), .carry_q(carry_q)
  );

  cpa_stage #(.GW(GW)) u_cpa (
    .clk(clk), .rst_n(rst_n), .fin_i(fin_i),
    .a_i(sum_q), .b_i(carry_q),
    .res_o(res_o), .valid_o(res_valid_o)
  );

  // Observation wires for the checks below
  logic [GW-1:0] tot_w, tot_plus_w;
  logic [CW-1:0] nops_q;
  logic          add_evt_w, load_evt_w;

  assign tot_w      = sum_q + carry_q;
  assign tot_plus_w = tot_w + op_ext_w;
  assign add_evt_w  = (upd_w == UPD_ADD);
  assign load_evt_w = (upd_w == UPD_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 nops_q <= '0;
    else if (load_evt_w)                        nops_q <= CW'(1);
    else if (add_evt_w && nops_q <= CW'(MAX_OPS)) nops_q <= nops_q + 1'b1;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt_w |=> (carry_q == '0) && (sum_q == {{XW{1'b0}}, $past(op_i)}));

  p_carry_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_evt_w |=> carry_q[0] == 1'b0);

  p_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_evt_w |=> tot_w == $past(tot_plus_w));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (add_evt_w && nops_q < CW'(MAX_OPS)) |-> !top_co_w);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(fin_i, 2));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> $stable(res_o));
endmodule

// File: tb/csa_accum_tb.sv
`timescale 1ns/1ps
module csa_accum_tb;
  localparam int W       = 8;
  localparam int MAX_OPS = 16;
  localparam int GW      = W + $clog2(MAX_OPS);
  localparam int MASK    = (1 << GW) - 1;
  localparam int ONES    = (1 << W) - 1;

  // entry: [4:0] operand count, [5] all-ones flag, [15:6] seed
  localparam logic [15:0] SEQ_TAB [8] = '{
    {10'd17,  1'b0, 5'd1},
    {10'd3,   1'b1, 5'd16},
    {10'd101, 1'b0, 5'd5},
    {10'd555, 1'b0, 5'd16},
    {10'd9,   1'b0, 5'd2},
    {10'd77,  1'b0, 5'd9},
    {10'd900, 1'b0, 5'd16},
    {10'd4,   1'b1, 5'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, add_i = 1'b0, fin_i = 1'b0;
  logic [W-1:0]  op_i = '0;
  logic [GW-1:0] res_o;
  logic          res_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] lcg;

  always #2.5 clk = ~clk;

  csa_accum #(.W(W), .MAX_OPS(MAX_OPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .add_i(add_i), .fin_i(fin_i),
    .op_i(op_i), .res_o(res_o), .res_valid_o(res_valid_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic ad, input logic fn, input int op);
    load_i = ld; add_i = ad; fin_i = fn; op_i = W'(op);
    @(negedge clk);
  endtask

  // finish request, then checks of the pulse timing and the value
  task automatic finish_and_check(input string req, input int exp);
    step(0, 0, 1, 0);
    check({req, " valid low on finish edge"}, int'(res_valid_o), 0);
    step(0, 0, 0, 0);
    check({req, " valid"}, int'(res_valid_o), 1);
    check({req, " result"}, int'(res_o), exp & MASK);
    step(0, 0, 0, 0);
    check({req, " valid pulse ends"}, int'(res_valid_o), 0);
  endtask

  function automatic int next_op();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[23:16]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid after reset", int'(res_valid_o), 0);
    check("R1 result after reset", int'(res_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_and_check("R1 empty total", 0);

    // R3 R4 R8: table of sequences, operands on back-to-back cycles
    for (int t = 0; t < 8; t++) begin
      int n;
      int gold;
      n = int'(SEQ_TAB[t][4:0]);
      lcg = {22'd0, SEQ_TAB[t][15:6]};
      gold = 0;
      for (int k = 0; k < n; k++) begin
        int op;
        op = SEQ_TAB[t][5] ? ONES : next_op();
        gold += op;
        step(k == 0, k != 0, 0, op);
      end
      finish_and_check(SEQ_TAB[t][5] ? "R8 all-ones sequence" : "R3 R4 sequence", gold);
    end

    // R2: load discards a previous total
    step(1, 0, 0, 200);
    step(0, 1, 0, 100);
    step(1, 0, 0, 9);
    finish_and_check("R2 reload", 9);

    // R9: load wins over a simultaneous add
    step(1, 1, 0, 7);
    finish_and_check("R9 load priority", 7);

    // R7: finish with load in the same cycle
    step(1, 0, 0, 10);
    step(0, 1, 0, 5);
    step(1, 0, 1, 3);
    check("R7 valid low on finish edge", int'(res_valid_o), 0);
    step(0, 1, 0, 4);
    check("R7 old total reported", int'(res_o), 15);
    check("R7 valid", int'(res_valid_o), 1);
    finish_and_check("R7 new total after load", 7);

    // R7: finish with add in the same cycle
    step(1, 0, 0, 20);
    step(0, 1, 1, 1);
    step(0, 0, 0, 0);
    check("R7 add-finish old total", int'(res_o), 20);
    step(0, 0, 0, 0);
    finish_and_check("R7 add applied", 21);

    // R11: finish leaves the total untouched
    finish_and_check("R11 repeat finish", 21);
    step(0, 1, 0, 30);
    finish_and_check("R11 continue adding", 51);

    // R6: result holds while idle
    repeat (5) step(0, 0, 0, 0);
    check("R6 result held", int'(res_o), 51);
    check("R6 valid stays low", int'(res_valid_o), 0);

    // R10: more than MAX_OPS operands wraps at the output width
    for (int k = 0; k < MAX_OPS + 1; k++) step(k == 0, k != 0, 0, ONES);
    finish_and_check("R10 wrap", (MAX_OPS + 1) * ONES);

    // R1: reset in mid-sequence clears everything
    step(1, 0, 0, 55);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid under reset", int'(res_valid_o), 0);
    check("R1 result under reset", int'(res_o), 0);
    rst_n = 1'b1;
    load_i = 1'b0;
    @(negedge clk);
    finish_and_check("R1 total cleared", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule